// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Unit

This block joins two eight-line interrupt cores into one sixteen-line controller. The first core (the primary) sees lines 0 to 7. The second core (the secondary) sees lines 8 to 15. Bit 3 of a line index selects the core. The secondary's request output feeds primary line 2, so that line cannot be driven from outside. Each core latches requests into a pending register. Each line is either edge or level sensitive, as set by that core's trigger-mode register. Priority is fixed inside each core: the lower line number wins. A request is wanted only when it outranks every line already in service.

When the processor pulses the acknowledge strobe, the block decides which line is served and sets the matching in-service bits. It then returns an 8-bit vector one clock later, together with a one-cycle valid pulse. The top five bits of the vector come from the serving core's programmed base, and the low three bits come from the line number. If no line is wanted, the vector points at line 7 of the core involved, and no in-service bit is set. An end-of-interrupt strobe with a 4-bit line index clears one in-service bit.

Top module: `cascade_irq_ack`

## Requirements
- R1: After reset, in_service, intr, vec_valid, mst_trig and slv_trig are all zero.
- R2: A write with cfg_sel=2 loads mst_trig with the data ANDed with 8'hF8. A write with cfg_sel=3 loads slv_trig with the data ANDed with 8'hDE. A 1 bit marks a line as level sensitive.
- R3: A write with cfg_sel=0 sets the primary base and cfg_sel=1 sets the secondary base. Only data bits 7..3 are kept, and vector bits 2..0 always equal the served line number within its core.
- R4: When the primary's wanted line L is not 2, an acknowledge returns primary base + L and sets in_service[L].
- R5: A wanted secondary line raises a request on primary line 2. An acknowledge of it returns secondary base + (line - 8) and sets both in_service[2] and that line's in_service bit.
- R6: If primary line 2 is served but the secondary no longer wants a line, the vector is secondary base + 7 and no secondary in-service bit is set.
- R7: An acknowledge with no wanted primary line returns primary base + 7 and leaves in_service unchanged.
- R8: vec_valid is high for exactly the one cycle after each cycle with ack_strb high.
- R9: Lower line numbers win within a core, and a line in service blocks requests of equal or lower priority. intr is re-evaluated after each acknowledge and each end-of-interrupt.
- R10: An edge-sensitive request is cleared by its acknowledge and needs a new rising edge to return. A level-sensitive request follows its input and survives acknowledge.
- R11: irq_lines[2] has no effect. Primary line 2 is driven only by the secondary.
- R12: An eoi_strb clears in_service[eoi_line].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | Request inputs, one per line |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 primary base, 1 secondary base, 2 primary trigger, 3 secondary trigger |
| cfg_data | input | 8 | Configuration write data |
| eoi_strb | input | 1 | End-of-interrupt strobe |
| eoi_line | input | 4 | Line whose in-service bit is cleared |
| ack_strb | input | 1 | Processor acknowledge strobe |
| intr | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid, one cycle after acknowledge |
| vec | output | 8 | Interrupt vector |
| in_service | output | 16 | In-service bits of both cores |
| mst_trig | output | 8 | Primary trigger-mode register |
| slv_trig | output | 8 | Secondary trigger-mode register |

## Verification
The bench drives every one of the fifteen external lines alone, as a single edge pulse, under several base pairs whose low bits are nonzero. This separates primary vectors from cascaded ones and confirms that the discarded base bits never reach the vector. Overlapping requests show the fixed order, the blocking by a line already in service, and that the cascade outranks primary line 3. A level line held through its acknowledge is contrasted with an edge line. The bench also builds a secondary request that disappears before the acknowledge, and pulses line 2 from outside, to reach both spurious paths.

// File: rtl/cascade_irq_ack.sv
module cascade_irq_ack #(
  parameter logic [7:0] MST_TRIG_MASK = 8'hF8,
  parameter logic [7:0] SLV_TRIG_MASK = 8'hDE,
  parameter int         CAS_LINE      = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_lines,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [7:0]  cfg_data,
  input  logic        eoi_strb,
  input  logic [3:0]  eoi_line,
  input  logic        ack_strb,
  output logic        intr,
  output logic        vec_valid,
  output logic [7:0]  vec,
  output logic [15:0] in_service,
  output logic [7:0]  mst_trig,
  output logic [7:0]  slv_trig
);

  localparam logic [7:0] CAS_BIT = 8'd1 << CAS_LINE;
  localparam logic [3:0] NONE    = 4'd8;

  function automatic logic [3:0] top_line(input logic [7:0] m);
    top_line = NONE;
    for (int i = 7; i >= 0; i--)
      if (m[i]) top_line = 4'(i);
  endfunction

  function automatic logic [7:0] next_req(input logic [7:0] req, input logic [7:0] last,
                                          input logic [7:0] lvl, input logic [7:0] trig,
                                          input logic [7:0] clr);
    for (int i = 0; i < 8; i++)
      next_req[i] = trig[i] ? lvl[i] : ((req[i] & ~clr[i]) | (lvl[i] & ~last[i]));
  endfunction

  logic [7:0] m_req, s_req, m_isr, s_isr, m_last, s_last;
  logic [4:0] m_base, s_base;
  logic [7:0] m_in, s_in;
  logic [3:0] m_pend, m_cur, s_pend, s_cur;
  logic       m_want, s_want, ack_m, ack_cas, ack_s;
  logic [7:0] m_clr, s_clr, m_eoi, s_eoi;

  assign m_in   = irq_lines[7:0] & ~CAS_BIT;
  assign s_in   = irq_lines[15:8];

  assign m_pend = top_line(m_req);
  assign m_cur  = top_line(m_isr);
  assign s_pend = top_line(s_req);
  assign s_cur  = top_line(s_isr);
  assign m_want = m_pend < m_cur;
  assign s_want = s_pend < s_cur;

  assign ack_m   = ack_strb & m_want;
  assign ack_cas = ack_m & (m_pend == 4'(CAS_LINE));
  assign ack_s   = ack_cas & s_want;

  assign m_clr = ack_m ? (8'd1 << m_pend[2:0]) : 8'd0;
  assign s_clr = ack_s ? (8'd1 << s_pend[2:0]) : 8'd0;
  assign m_eoi = (eoi_strb && !eoi_line[3]) ? (8'd1 << eoi_line[2:0]) : 8'd0;
  assign s_eoi = (eoi_strb &&  eoi_line[3]) ? (8'd1 << eoi_line[2:0]) : 8'd0;

  assign intr       = m_want;
  assign in_service = {s_isr, m_isr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_req <= '0; s_req <= '0; m_isr <= '0; s_isr <= '0;
      m_last <= '0; s_last <= '0;
      m_base <= '0; s_base <= '0;
      mst_trig <= '0; slv_trig <= '0;
      vec_valid <= 1'b0; vec <= '0;
    end else begin
      m_last <= m_in;
      s_last <= s_in;
      m_req  <= next_req(m_req, m_last, m_in, mst_trig, m_clr)
              | ((s_want && !ack_strb) ? CAS_BIT : 8'd0);
      s_req  <= next_req(s_req, s_last, s_in, slv_trig, s_clr);
      m_isr  <= (m_isr & ~m_eoi) | m_clr;
      s_isr  <= (s_isr & ~s_eoi) | s_clr;
      if (cfg_we)
        case (cfg_sel)
          2'd0: m_base   <= cfg_data[7:3];
          2'd1: s_base   <= cfg_data[7:3];
          2'd2: mst_trig <= cfg_data & MST_TRIG_MASK;
          2'd3: slv_trig <= cfg_data & SLV_TRIG_MASK;
        endcase
      vec_valid <= ack_strb;
      if (ack_strb) begin
        if (!m_want)      vec <= {m_base, 3'd7};
        else if (!ack_cas) vec <= {m_base, m_pend[2:0]};
        else if (s_want)  vec <= {s_base, s_pend[2:0]};
        else              vec <= {s_base, 3'd7};
      end
    end
  end

endmodule

// File: rtl/cascade_irq_ack_chk.sv
module cascade_irq_ack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ack_strb,
  input logic        eoi_strb,
  input logic        intr,
  input logic        vec_valid,
  input logic [7:0]  vec,
  input logic [15:0] in_service,
  input logic [7:0]  mst_trig,
  input logic [7:0]  slv_trig
);

  a_r8_valid_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_strb |=> vec_valid);

  a_r8_valid_only_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack_strb));

  a_r2_trig_readonly_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ((mst_trig & 8'h07) == 8'd0) && ((slv_trig & 8'h21) == 8'd0));

  a_r7_spurious_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_strb && !intr) |=> (vec[2:0] == 3'd7));

  a_r7_spurious_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_strb && !intr && !eoi_strb) |=> (in_service == $past(in_service)));

  a_r5_secondary_needs_cascade: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(in_service[15:8]) > $countones($past(in_service[15:8]))) |-> in_service[2]);

endmodule

bind cascade_irq_ack cascade_irq_ack_chk u_chk (.*);

// File: tb/sim_cascade_irq_ack.sv
module sim_cascade_irq_ack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_lines = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_data = '0;
  logic        eoi_strb = 1'b0;
  logic [3:0]  eoi_line = '0;
  logic        ack_strb = 1'b0;
  logic        intr, vec_valid;
  logic [7:0]  vec, mst_trig, slv_trig;
  logic [15:0] in_service;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cascade_irq_ack u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic eoi(input logic [3:0] ln);
    @(negedge clk); eoi_strb = 1'b1; eoi_line = ln;
    @(negedge clk); eoi_strb = 1'b0;
  endtask

  task automatic pulse(input int ln);
    @(negedge clk); irq_lines[ln] = 1'b1;
    @(negedge clk); irq_lines[ln] = 1'b0;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); ack_strb = 1'b1;
    @(negedge clk); ack_strb = 1'b0;
    check("R8 valid after ack", vec_valid, 1);
    v = vec;
    @(negedge clk);
    check("R8 valid one cycle", vec_valid, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, mb, sb;
    logic [7:0] bases [3] = '{8'h27, 8'h7B, 8'hF5};
    cyc(3);
    check("R1 isr", in_service, 0);
    check("R1 intr", intr, 0);
    check("R1 valid", vec_valid, 0);
    check("R1 trig", {mst_trig, slv_trig}, 0);
    @(negedge clk); rst_n = 1'b1;

    cfg(2, 8'hFF); cfg(3, 8'hFF);
    check("R2 primary trig mask", mst_trig, 8'hF8);
    check("R2 secondary trig mask", slv_trig, 8'hDE);
    cfg(2, 8'h00); cfg(3, 8'h00);
    check("R2 trig cleared", {mst_trig, slv_trig}, 0);

    for (int b = 0; b < 3; b++) begin
      mb = bases[b]; sb = bases[(b + 1) % 3];
      cfg(0, mb); cfg(1, sb);
      for (int ln = 0; ln < 16; ln++) begin
        if (ln == 2) continue;
        pulse(ln); cyc(2);
        check(ln < 8 ? "R4 intr" : "R5 intr via cascade", intr, 1);
        ack(v);
        if (ln < 8) begin
          check("R3 R4 primary vector", v, (mb & 8'hF8) + 8'(ln));
          check("R4 isr", in_service, 16'd1 << ln);
        end else begin
          check("R3 R5 secondary vector", v, (sb & 8'hF8) + 8'(ln - 8));
          check("R5 isr both", in_service, (16'd1 << ln) | 16'h0004);
        end
        check("R10 edge cleared by ack", intr, 0);
        eoi(4'(ln));
        if (ln >= 8) eoi(4'd2);
        check("R12 eoi clears", in_service, 0);
      end
    end
    mb = 8'h20; sb = 8'h70;
    cfg(0, mb); cfg(1, sb);

    @(negedge clk); irq_lines[2] = 1'b1; cyc(3);
    check("R11 line 2 ignored", intr, 0);
    ack(v);
    check("R7 primary spurious", v, mb + 7);
    check("R7 isr unchanged", in_service, 0);
    irq_lines[2] = 1'b0;

    pulse(5); pulse(6); cyc(1);
    ack(v);
    check("R9 lower line first", v, mb + 5);
    check("R9 line 6 blocked by 5", intr, 0);
    pulse(1); cyc(1);
    check("R9 line 1 preempts", intr, 1);
    ack(v);
    check("R9 vector line 1", v, mb + 1);
    eoi(1); eoi(5); cyc(1);
    check("R9 intr after eoi", intr, 1);
    ack(v);
    check("R9 line 6 served", v, mb + 6);
    eoi(6);

    pulse(3); pulse(8); cyc(2);
    ack(v);
    check("R9 R5 cascade beats line 3", v, sb + 0);
    eoi(8); eoi(2); cyc(1);
    ack(v);
    check("R9 line 3 after", v, mb + 3);
    eoi(3);

    cfg(2, 8'h08);
    @(negedge clk); irq_lines[3] = 1'b1; cyc(2);
    ack(v);
    check("R10 level vector", v, mb + 3);
    eoi(3); cyc(1);
    check("R10 level survives ack", intr, 1);
    @(negedge clk); irq_lines[3] = 1'b0; cyc(2);
    check("R10 level follows input", intr, 0);
    cfg(2, 8'h00);

    cfg(3, 8'h02);
    @(negedge clk); irq_lines[9] = 1'b1; cyc(3);
    @(negedge clk); irq_lines[9] = 1'b0; cyc(2);
    check("R6 cascade request latched", intr, 1);
    ack(v);
    check("R6 secondary spurious", v, sb + 7);
    check("R6 only cascade in service", in_service, 16'h0004);
    eoi(2);
    check("R12 final isr", in_service, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule